// File: doc/BRIEF.md
# A-MPDU Frame Count Planner

This block decides how many queued MPDUs go into the next aggregated transmission. A start pulse opens a plan. The block then takes candidate MPDU lengths from a valid/ready stream. Each length already counts padding and delimiters. A candidate is accepted only while the running frame count and the running byte total both stay within their programmed caps. Planning ends at the first candidate that does not fit, or when the stream runs dry. The candidate that did not fit is not consumed, so it heads the stream for the next plan.

When the plan closes, the block raises a one-cycle done strobe with these results:
- the accepted frame count and the total bytes;
- an end-of-service-period flag, set when the count matches its threshold;
- a More Data flag, set when the count falls short of a second threshold;
- a queue-level more-data flag, reported only when the destination is in power save and a candidate was left waiting.

The configuration inputs must be held stable from start until done.

Top module: `ampdu_count_planner`

## Requirements
- R1: After synchronous reset, done, candReady, planCount, planBytes and all three flags are 0.
- R2: The summed length of the accepted candidates never exceeds cfgMaxBytes (20 bits). A candidate that brings the sum exactly to cfgMaxBytes is accepted.
- R3: No more than cfgMaxCount (7 bits) candidates are accepted in one plan. A cap of 0 accepts none.
- R4: Planning stops at the first candidate that would break either cap. That candidate sees candReady low and stays at the head of the stream.
- R5: If candValid is low in any planning cycle, the plan ends there.
- R6: done is a one-cycle pulse that follows the last planning cycle. At done, planCount equals the number of accepted candidates and planBytes equals their summed length.
- R7: A plan that accepts nothing ends with planCount 0 and with eospFlag and moreFlag both 0, whatever the enables and thresholds are.
- R8: At done, eospFlag is 1 exactly when cfgEospEn is 1, planCount equals cfgEospThr, and planCount is nonzero.
- R9: At done, moreFlag is 1 exactly when cfgMoreEn is 1, planCount is below cfgMoreThr, and planCount is nonzero.
- R10: With its enable at 0, eospFlag or moreFlag stays 0 for every threshold value.
- R11: At done, queueMoreFlag is 1 exactly when peerDozing is 1 and a candidate was still valid at the head of the stream when the plan ended.
- R12: A start pulse that arrives while a plan is running has no effect. The counts keep accumulating from where they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that opens a new plan when idle |
| cfgMaxBytes | input | 20 | Byte cap for the aggregate |
| cfgMaxCount | input | 7 | Frame count cap |
| cfgEospEn | input | 1 | Enables the end-of-service-period flag |
| cfgEospThr | input | 7 | Count at which the end-of-service-period flag is set |
| cfgMoreEn | input | 1 | Enables the More Data flag |
| cfgMoreThr | input | 7 | More Data flag is set for counts below this |
| peerDozing | input | 1 | Destination is in power save |
| candValid | input | 1 | A candidate length is presented |
| candLen | input | LEN_W (14) | Byte length of the candidate |
| candReady | output | 1 | Candidate is accepted in this cycle |
| done | output | 1 | One-cycle plan-complete strobe |
| planCount | output | 7 | Accepted frame count |
| planBytes | output | 20 | Accepted byte total |
| eospFlag | output | 1 | End-of-service-period indication |
| moreFlag | output | 1 | More Data indication |
| queueMoreFlag | output | 1 | Queue-level more-data indication |

## Verification
The bench sweeps the count cap from 0 to 5 against four byte caps: zero, a tight cap, a cap equal to the exact sum of the first three lengths, and an ample cap. Stream depths vary with the configuration, so the same sweep separates three ways a plan can stop: on the byte cap, on the count cap, or on an empty stream. It also checks the equal-sum boundary and the untouched head candidate. A second sweep fixes the accepted count and walks both thresholds and both enables through every value near that count, which isolates the equality and less-than comparisons from the zero-count gating. One directed plan pulses start in the middle of planning and checks that the totals are unaffected.

// File: rtl/planner_pkg.sv
package planner_pkg;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_PLAN = 1'b1
  } planState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;   // zero the accumulators
    logic accept;  // add the head candidate
    logic finish;  // last planning cycle: latch flags, raise done
    logic active;  // a plan is in progress
  } planStrobe_t;

endpackage

// File: rtl/planner_ctrl.sv
module planner_ctrl
  import planner_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        candValid,
  input  logic        fits,
  output logic        candReady,
  output planStrobe_t strobe
);

  planState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    strobe        = '0;
    strobe.active = (state == PS_PLAN);
    unique case (state)
      PS_IDLE: begin
        if (start) begin
          strobe.clear = 1'b1;
          stateNext    = PS_PLAN;
        end
      end
      PS_PLAN: begin
        if (candValid && fits) begin
          strobe.accept = 1'b1;
        end else begin
          strobe.finish = 1'b1;
          stateNext     = PS_IDLE;
        end
      end
      default: stateNext = PS_IDLE;
    endcase
  end

  assign candReady = strobe.accept;

  always_ff @(posedge clk) begin
    if (rst) state <= PS_IDLE;
    else     state <= stateNext;
  end

  // R1: nothing is accepted outside a plan
  a_r1_idle_no_ready: assert property (@(posedge clk) disable iff (rst)
    (state == PS_IDLE) |-> !candReady);

  // R4: a refused head candidate closes the plan
  a_r4_refuse_ends: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PLAN && candValid && !candReady) |=> (state == PS_IDLE));

  // R12: start during a plan does not reopen or clear it
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == PS_PLAN && start) |-> !strobe.clear);

endmodule

// File: rtl/planner_dp.sv
module planner_dp
  import planner_pkg::*;
#(
  parameter int COUNT_W = 7,
  parameter int BYTES_W = 20,
  parameter int LEN_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  planStrobe_t        strobe,
  input  logic [BYTES_W-1:0] cfgMaxBytes,
  input  logic [COUNT_W-1:0] cfgMaxCount,
  input  logic               cfgEospEn,
  input  logic [COUNT_W-1:0] cfgEospThr,
  input  logic               cfgMoreEn,
  input  logic [COUNT_W-1:0] cfgMoreThr,
  input  logic               peerDozing,
  input  logic               candValid,
  input  logic [LEN_W-1:0]   candLen,
  output logic               fits,
  output logic               done,
  output logic [COUNT_W-1:0] planCount,
  output logic [BYTES_W-1:0] planBytes,
  output logic               eospFlag,
  output logic               moreFlag,
  output logic               queueMoreFlag
);

  localparam int SUM_W = ((BYTES_W > LEN_W) ? BYTES_W : LEN_W) + 1;

  logic [COUNT_W-1:0] accCount;
  logic [BYTES_W-1:0] accBytes;
  logic [SUM_W-1:0]   sumNext;
  logic               roomCount;
  logic               roomBytes;
  logic               nonZero;

  assign sumNext   = SUM_W'(accBytes) + SUM_W'(candLen);
  assign roomCount = (accCount < cfgMaxCount);
  assign roomBytes = (sumNext <= SUM_W'(cfgMaxBytes));
  assign fits      = roomCount && roomBytes;
  assign nonZero   = (accCount != '0);

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      accCount <= '0;
      accBytes <= '0;
    end else if (strobe.accept) begin
      accCount <= accCount + COUNT_W'(1);
      accBytes <= accBytes + BYTES_W'(candLen);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done          <= 1'b0;
      eospFlag      <= 1'b0;
      moreFlag      <= 1'b0;
      queueMoreFlag <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.clear) begin
        eospFlag      <= 1'b0;
        moreFlag      <= 1'b0;
        queueMoreFlag <= 1'b0;
      end else if (strobe.finish) begin
        eospFlag      <= cfgEospEn && nonZero && (accCount == cfgEospThr);
        moreFlag      <= cfgMoreEn && nonZero && (accCount < cfgMoreThr);
        queueMoreFlag <= peerDozing && candValid;
      end
    end
  end

  assign planCount = accCount;
  assign planBytes = accBytes;

  // R2: running byte total stays within the cap
  a_r2_byte_cap: assert property (@(posedge clk) disable iff (rst)
    strobe.active |-> (accBytes <= cfgMaxBytes));

  // R3: running count stays within the cap
  a_r3_count_cap: assert property (@(posedge clk) disable iff (rst)
    strobe.active |-> (accCount <= cfgMaxCount));

  // R6: each accept advances the count by one
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    strobe.accept |=> (accCount == $past(accCount) + COUNT_W'(1)));

  // R6: done is a single-cycle strobe
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: an empty plan carries no per-frame flags
  a_r7_empty_quiet: assert property (@(posedge clk) disable iff (rst)
    (done && planCount == '0) |-> (!eospFlag && !moreFlag));

  // R10: flags need their enables
  a_r10_enables: assert property (@(posedge clk) disable iff (rst)
    done |-> ((!eospFlag || cfgEospEn) && (!moreFlag || cfgMoreEn)));

  // R11: queue-level indication only for a dozing peer
  a_r11_dozing: assert property (@(posedge clk) disable iff (rst)
    (done && queueMoreFlag) |-> peerDozing);

endmodule

// File: rtl/ampdu_count_planner.sv
module ampdu_count_planner
  import planner_pkg::*;
#(
  parameter int COUNT_W = 7,
  parameter int BYTES_W = 20,
  parameter int LEN_W   = 14
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [BYTES_W-1:0] cfgMaxBytes,
  input  logic [COUNT_W-1:0] cfgMaxCount,
  input  logic               cfgEospEn,
  input  logic [COUNT_W-1:0] cfgEospThr,
  input  logic               cfgMoreEn,
  input  logic [COUNT_W-1:0] cfgMoreThr,
  input  logic               peerDozing,
  input  logic               candValid,
  input  logic [LEN_W-1:0]   candLen,
  output logic               candReady,
  output logic               done,
  output logic [COUNT_W-1:0] planCount,
  output logic [BYTES_W-1:0] planBytes,
  output logic               eospFlag,
  output logic               moreFlag,
  output logic               queueMoreFlag
);

  planStrobe_t strobe;
  logic        fits;

  planner_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .candValid (candValid),
    .fits      (fits),
    .candReady (candReady),
    .strobe    (strobe)
  );

  planner_dp #(
    .COUNT_W (COUNT_W),
    .BYTES_W (BYTES_W),
    .LEN_W   (LEN_W)
  ) u_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .cfgMaxBytes   (cfgMaxBytes),
    .cfgMaxCount   (cfgMaxCount),
    .cfgEospEn     (cfgEospEn),
    .cfgEospThr    (cfgEospThr),
    .cfgMoreEn     (cfgMoreEn),
    .cfgMoreThr    (cfgMoreThr),
    .peerDozing    (peerDozing),
    .candValid     (candValid),
    .candLen       (candLen),
    .fits          (fits),
    .done          (done),
    .planCount     (planCount),
    .planBytes     (planBytes),
    .eospFlag      (eospFlag),
    .moreFlag      (moreFlag),
    .queueMoreFlag (queueMoreFlag)
  );

endmodule

// File: tb/tb_ampdu_count_planner.sv
module tb_ampdu_count_planner;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [19:0] cfgMaxBytes;
  logic [6:0]  cfgMaxCount;
  logic        cfgEospEn;
  logic [6:0]  cfgEospThr;
  logic        cfgMoreEn;
  logic [6:0]  cfgMoreThr;
  logic        peerDozing;
  logic        candValid;
  logic [13:0] candLen;
  logic        candReady;
  logic        done;
  logic [6:0]  planCount;
  logic [19:0] planBytes;
  logic        eospFlag;
  logic        moreFlag;
  logic        queueMoreFlag;

  int total = 0;
  int bad   = 0;
  int lens [8];
  int nCand;
  int head;
  bit hung = 0;

  always #10 clk = ~clk;  // 50 MHz

  ampdu_count_planner dut (
    .clk(clk), .rst(rst), .start(start),
    .cfgMaxBytes(cfgMaxBytes), .cfgMaxCount(cfgMaxCount),
    .cfgEospEn(cfgEospEn), .cfgEospThr(cfgEospThr),
    .cfgMoreEn(cfgMoreEn), .cfgMoreThr(cfgMoreThr),
    .peerDozing(peerDozing), .candValid(candValid), .candLen(candLen),
    .candReady(candReady), .done(done), .planCount(planCount),
    .planBytes(planBytes), .eospFlag(eospFlag), .moreFlag(moreFlag),
    .queueMoreFlag(queueMoreFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveStream();
    candValid = (head < nCand);
    candLen   = (head < nCand) ? 14'(lens[head]) : 14'd0;
  endtask

  task automatic runPlan(input bit midStart);
    int  eCount = 0;
    int  eBytes = 0;
    bit  eLeft  = 0;
    bit  eEosp, eMore, eQm;
    bit  acc = 0;
    int  guard = 0;
    // greedy model from the requirements
    for (int i = 0; i < nCand; i++) begin
      if (eCount == int'(cfgMaxCount) || eBytes + lens[i] > int'(cfgMaxBytes)) begin
        eLeft = 1;
        break;
      end
      eCount++;
      eBytes += lens[i];
    end
    eEosp = cfgEospEn && eCount != 0 && eCount == int'(cfgEospThr);
    eMore = cfgMoreEn && eCount != 0 && eCount < int'(cfgMoreThr);
    eQm   = peerDozing && eLeft;

    head = 0;
    @(negedge clk);
    driveStream();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (acc) head++;
      driveStream();
      if (midStart) start = (guard == 2);
      #1;
      if (done) break;
      acc = candValid && candReady;
      guard++;
      if (guard > 200) begin
        hung = 1;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(!hung, "R6 done seen", int'(hung), 0);
    chk(int'(planCount) == eCount, "R3/R6 count", planCount, eCount);
    chk(int'(planBytes) == eBytes, "R2/R6 bytes", planBytes, eBytes);
    chk(head == eCount, "R4/R5 consumed", head, eCount);
    chk(eospFlag == eEosp, "R8/R7 eosp", eospFlag, eEosp);
    chk(moreFlag == eMore, "R9/R7 more", moreFlag, eMore);
    chk(queueMoreFlag == eQm, "R11 queue more", queueMoreFlag, eQm);
    @(negedge clk);
    chk(!done, "R6 done pulse width", done, 0);
    chk(!candReady, "R4 idle ready low", candReady, 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0;
    cfgMaxBytes = '0; cfgMaxCount = '0; cfgEospEn = 0; cfgEospThr = '0;
    cfgMoreEn = 0; cfgMoreThr = '0; peerDozing = 0;
    candValid = 0; candLen = '0;
    nCand = 0; head = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!done && !candReady, "R1 strobes", {done, candReady}, 0);
    chk(planCount == 0 && planBytes == 0, "R1 totals", planBytes, 0);
    chk(!eospFlag && !moreFlag && !queueMoreFlag, "R1 flags",
        {eospFlag, moreFlag, queueMoreFlag}, 0);

    // sweep: count cap x byte cap, stream depth and thresholds derived
    for (int mc = 0; mc <= 5; mc++) begin
      for (int mb = 0; mb < 4; mb++) begin
        for (int i = 0; i < 8; i++) lens[i] = 10 + ((i * 7 + mc + mb) % 5) * 5;
        nCand       = (mc + 2 * mb + 1) % 8;
        cfgMaxCount = 7'(mc);
        case (mb)
          0: cfgMaxBytes = 20'd0;
          1: cfgMaxBytes = 20'd40;
          2: cfgMaxBytes = 20'(lens[0] + lens[1] + lens[2]);  // R2 equality edge
          default: cfgMaxBytes = 20'd100000;
        endcase
        cfgEospEn  = ((mc + mb) % 3) != 0;
        cfgEospThr = 7'((mc + mb) % 6);
        cfgMoreEn  = ((mc * mb) % 2) == 0;
        cfgMoreThr = 7'((mc * 3 + mb) % 7);
        peerDozing = (mb % 2) == 1;
        runPlan(1'b0);
      end
    end

    // R8 R9 R10: fixed count of 3, walk thresholds and enables
    for (int i = 0; i < 8; i++) lens[i] = 20;
    nCand = 5; cfgMaxCount = 7'd3; cfgMaxBytes = 20'd1000; peerDozing = 1;
    for (int en = 0; en < 4; en++) begin
      for (int t = 0; t < 6; t++) begin
        cfgEospEn  = en[0];
        cfgMoreEn  = en[1];
        cfgEospThr = 7'(t);
        cfgMoreThr = 7'(t);
        runPlan(1'b0);
      end
    end

    // R12: start pulse while planning
    for (int i = 0; i < 8; i++) lens[i] = 10;
    nCand = 6; cfgMaxCount = 7'd7; cfgMaxBytes = 20'd1000;
    cfgEospEn = 1; cfgEospThr = 7'd6; cfgMoreEn = 1; cfgMoreThr = 7'd7;
    peerDozing = 0;
    runPlan(1'b1);
    chk(planCount == 7'd6, "R12 count after mid start", planCount, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule